// File: doc/BRIEF.md
# Bus Time-Out and Watchdog Supervisor

This block watches the system bus and the software. Its first function is a bus time-out counter. The counter runs while the active-low bus-busy input is held low and flags any bus cycle that outlasts a selectable limit. Its second function is a watchdog counter that software loads with a 16-bit count. The watchdog counts down on a timebase tick and expires if software does not reload it in time.

Both timebase ticks come from a programmed clock-frequency value in MHz. The 1 MHz tick divides the core clock by that value. The 1 kHz tick divides the 1 MHz tick by 1000. Each function raises the same active-high terminal-count pulse and sets its own sticky status flag. Software clears the flags by reading them.

Software reaches the block through a single-cycle write port. The select input picks either the program register or the watchdog register. A read strobe returns the status flags and then clears them.

Top module: `bus_supervisor`

## Requirements
- R1: After reset, `tc_out` is low, `stat_q` is 0, and the program and watchdog registers hold 0. A watchdog count of 0 never expires, even if the watchdog is later enabled.
- R2: A write with `wr_sel`=0 loads the program register from `wr_data`. The layout is bits [5:0] clock frequency in MHz, bit 6 bus time-out enable, bit 7 long limit select, bit 8 watchdog enable and bit 9 slow (1 kHz) tick select. Any register write restarts both timebase dividers.
- R3: The 1 MHz tick occurs once every M clocks, where M is the programmed frequency and counting starts from the restarting write. When M is 0, no tick is produced.
- R4: With time-out enabled and bit 7 clear, bus-busy low at 64 consecutive clock edges gives a terminal-count pulse after the 64th edge.
- R5: With bit 7 set, the limit is 128 consecutive low-sampled edges. A run of 127 edges gives no pulse.
- R6: Releasing bus-busy clears the time-out count, so a low run shorter than the limit gives no pulse and the next run starts again from zero.
- R7: With bus time-out enable clear, bus-busy low for any length gives no pulse and no flag.
- R8: With the watchdog enabled on the 1 MHz tick, writing count N (`wr_sel`=1) gives a terminal-count pulse N·M clocks after the write edge, and sets status bit 0.
- R9: With the slow tick selected, the expiry falls 1000·N·M clocks after the write edge.
- R10: Writing the watchdog register again reloads the count and restarts the wait. Writing 0 cancels a pending expiry.
- R11: With watchdog enable clear, the count is frozen. After the watchdog is enabled, the countdown continues from the frozen value.
- R12: Each event gives a one-cycle `tc_out` pulse. A watchdog expiry sets status bit 0 and a bus time-out sets bit 1, in the same cycle as the pulse. A single long bus cycle gives only one pulse.
- R13: Status flags stay set until a cycle with `stat_rd` high. That edge clears them, unless a new event sets a flag on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_sel | input | 1 | 0 selects the program register, 1 selects the watchdog register |
| wr_data | input | 16 | Write data |
| stat_rd | input | 1 | Status read strobe; clears the flags at that edge |
| stat_q | output | 2 | Sticky flags: bit 0 watchdog expiry, bit 1 bus time-out |
| bus_busy_n | input | 1 | Bus busy, active low |
| tc_out | output | 1 | Terminal-count pulse, active high |

## Verification
The edge where a write, read or bus-busy sample takes effect is the reference point for timing. A watchdog pulse is due in the cycle that follows edge W+N·M, or W+1000·N·M on the slow tick. A time-out pulse is due in the cycle after the limit-th low-sampled edge, and flags show up together with the pulse. The bench counts edges and stores the exact due edge for each expected pulse when it drives the stimulus. A monitor samples at the falling clock edge and matches each pulse against that stored edge, so a pulse that comes one cycle early or late fails. Idle windows and read-clear checks confirm at the outputs that suppressed events leave no pulse and no flag.

// File: rtl/bsup_pkg.sv
// Shared definitions for the bus supervisor.
// Assumes one program register whose field layout is fixed by the struct below.
package bsup_pkg;

    localparam int MHZ_W = 6;

    // Program register layout, least significant field last.
    typedef struct packed {
        logic             wdg_slow;   // bit 9: 1 kHz tick when set
        logic             wdg_en;     // bit 8
        logic             bto_long;   // bit 7: 128-cycle limit when set
        logic             bto_en;     // bit 6
        logic [MHZ_W-1:0] mhz;        // bits 5:0
    } prog_t;

    localparam int PROG_W = $bits(prog_t);

    // Status flag positions.
    localparam int ST_WDG = 0;
    localparam int ST_BTO = 1;
    localparam int ST_W   = 2;

endpackage

// File: rtl/bsup_tick_gen.sv
// Timebase divider: makes a 1 MHz tick from the core clock and a 1 kHz tick from that.
// Assumes mhz changes only in a cycle after restart is high. mhz = 0 stops both ticks.
module bsup_tick_gen #(
    parameter int MHZ_W  = 6,
    parameter int MS_DIV = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [MHZ_W-1:0] mhz,
    output logic             us_tick,
    output logic             ms_tick
);

    localparam int              MS_W    = $clog2(MS_DIV);
    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_DIV - 1);

    logic [MHZ_W-1:0] pre_cnt;
    logic [MHZ_W-1:0] mhz_m1;
    logic [MS_W-1:0]  ms_cnt;

    assign mhz_m1  = mhz - 1'b1;
    assign us_tick = (mhz != '0) && (pre_cnt == mhz_m1);
    assign ms_tick = us_tick && (ms_cnt == MS_LAST);

    // Prescaler: counts core clocks from 0 to mhz-1.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || (mhz == '0)) begin
            pre_cnt <= '0;
        end else if (us_tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // Millisecond divider: counts 1 MHz ticks from 0 to MS_DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ms_cnt <= '0;
        end else if (ms_tick) begin
            ms_cnt <= '0;
        end else if (us_tick) begin
            ms_cnt <= ms_cnt + 1'b1;
        end
    end

    // R3
    us_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (us_tick && (mhz > MHZ_W'(1)) && !restart) |=> !us_tick);

    // R9
    ms_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_tick && !restart) |=> !ms_tick);

endmodule

// File: rtl/bsup_bus_timeout.sv
// Bus time-out: counts consecutive edges with bus busy low and fires once at the limit.
// Assumes bus_busy_n is synchronous to clk. The counter saturates after firing until the bus is released.
module bsup_bus_timeout #(
    parameter int SHORT_LIM = 64,
    parameter int LONG_LIM  = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic long_sel,
    input  logic bus_busy_n,
    output logic fire
);

    localparam int CNT_W = $clog2(LONG_LIM) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = long_sel ? CNT_W'(LONG_LIM) : CNT_W'(SHORT_LIM);
    assign fire  = en && !bus_busy_n && (cnt == limit - 1'b1);

    // Busy-run counter: clears when idle or disabled, holds at the limit after firing.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || bus_busy_n) begin
            cnt <= '0;
        end else if (fire) begin
            cnt <= limit;
        end else if (cnt < limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R12
    one_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    // R6
    idle_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy_n |=> (cnt == '0));

    // R4
    fire_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(!bus_busy_n));

endmodule

// File: rtl/bsup_wdg_timer.sv
// Watchdog countdown: loads a count, decrements on the selected tick and fires on the step from 1 to 0.
// Assumes a count of 0 is idle. A load in the same cycle takes priority over a decrement.
module bsup_wdg_timer #(
    parameter int WDG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WDG_W-1:0] load_val,
    input  logic             en,
    input  logic             tick,
    output logic             fire
);

    logic [WDG_W-1:0] cnt;

    assign fire = !load && en && tick && (cnt == WDG_W'(1));

    // Countdown register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (en && tick && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(cnt));

    // R8
    zero_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cnt == '0));

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == '0) && !load) |=> (cnt == '0));

endmodule

// File: rtl/bus_supervisor.sv
// Bus supervisor top: program register, watchdog load, shared terminal count and sticky status.
// Assumes single-cycle write and read strobes. Any write restarts the timebase.
module bus_supervisor #(
    parameter int WDG_W     = 16,
    parameter int MS_DIV    = 1000,
    parameter int SHORT_LIM = 64,
    parameter int LONG_LIM  = 128
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_sel,
    input  logic [WDG_W-1:0]          wr_data,
    input  logic                      stat_rd,
    output logic [bsup_pkg::ST_W-1:0] stat_q,
    input  logic                      bus_busy_n,
    output logic                      tc_out
);

    import bsup_pkg::*;

    prog_t            prog_q;
    logic             us_tick;
    logic             ms_tick;
    logic             wdg_tick;
    logic             wdg_fire;
    logic             bto_fire;
    logic             wdg_load;
    logic [ST_W-1:0]  fire_vec;
    logic [ST_W-1:0]  flags;
    logic             tc_q;

    assign wdg_load         = wr_en && wr_sel;
    assign wdg_tick         = prog_q.wdg_slow ? ms_tick : us_tick;
    assign fire_vec[ST_WDG] = wdg_fire;
    assign fire_vec[ST_BTO] = bto_fire;
    assign stat_q           = flags;
    assign tc_out           = tc_q;

    // Program register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_q <= '0;
        end else if (wr_en && !wr_sel) begin
            prog_q <= prog_t'(wr_data[PROG_W-1:0]);
        end
    end

    bsup_tick_gen #(
        .MHZ_W  (MHZ_W),
        .MS_DIV (MS_DIV)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_en),
        .mhz     (prog_q.mhz),
        .us_tick (us_tick),
        .ms_tick (ms_tick)
    );

    bsup_bus_timeout #(
        .SHORT_LIM (SHORT_LIM),
        .LONG_LIM  (LONG_LIM)
    ) u_bto (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (prog_q.bto_en),
        .long_sel   (prog_q.bto_long),
        .bus_busy_n (bus_busy_n),
        .fire       (bto_fire)
    );

    bsup_wdg_timer #(
        .WDG_W (WDG_W)
    ) u_wdg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wdg_load),
        .load_val (wr_data),
        .en       (prog_q.wdg_en),
        .tick     (wdg_tick),
        .fire     (wdg_fire)
    );

    // Shared terminal-count pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q <= 1'b0;
        end else begin
            tc_q <= |fire_vec;
        end
    end

    // Sticky flags: a read clears them and a new event in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= fire_vec | (stat_rd ? '0 : flags);
        end
    end

    // R12
    tc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_out |-> (stat_q != '0));

    // R13
    rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && (fire_vec == '0)) |=> (stat_q == '0));

    // R13
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

endmodule

// File: tb/sim_bus_supervisor.sv
`timescale 1ns/1ps
module sim_bus_supervisor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        stat_rd = 1'b0;
    logic [1:0]  stat_q;
    logic        bus_busy_n = 1'b1;
    logic        tc_out;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int exp_cyc[$];
    int exp_bit[$];
    logic tc_prev = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bus_supervisor u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .stat_rd    (stat_rd),
        .stat_q     (stat_q),
        .bus_busy_n (bus_busy_n),
        .tc_out     (tc_out)
    );

    // Monitor: match every pulse against the scoreboard (R12 pulse width).
    always @(negedge clk) begin
        if (rst_n) begin
            if (tc_prev) begin
                n_chk++;
                if (tc_out) begin
                    n_err++;
                    $display("FAIL R12 tc width at edge %0d: got 1 expected 0", cyc);
                end
            end else if (tc_out) begin
                int hit;
                hit = -1;
                n_chk++;
                foreach (exp_cyc[i]) if (hit < 0 && exp_cyc[i] == cyc) hit = i;
                if (hit < 0) begin
                    n_err++;
                    $display("FAIL R12 unexpected tc at edge %0d, expected %0d", cyc,
                             (exp_cyc.size() > 0) ? exp_cyc[0] : -1);
                end else begin
                    if (!stat_q[exp_bit[hit]]) begin
                        n_err++;
                        $display("FAIL R12 flag at edge %0d: stat %0d, expected bit %0d set",
                                 cyc, stat_q, exp_bit[hit]);
                    end
                    exp_cyc.delete(hit);
                    exp_bit.delete(hit);
                end
            end
            tc_prev = tc_out;
        end
    end

    function automatic logic [15:0] prog(input int mhz, input bit bto_en, input bit lng,
                                         input bit wen, input bit slow);
        return {6'b0, slow, wen, lng, bto_en, 6'(mhz)};
    endfunction

    task automatic wr(input bit sel, input logic [15:0] d, output int w);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        w = cyc;
    endtask

    task automatic arm(input int n, input int mhz, input bit slow);
        int w;
        wr(1'b1, 16'(n), w);
        exp_cyc.push_back(w + n * mhz * (slow ? 1000 : 1));
        exp_bit.push_back(0);
    endtask

    task automatic check_stat(input logic [1:0] e, input string tag);
        @(negedge clk);
        n_chk++;
        if (stat_q !== e || tc_out !== 1'b0 && !tc_prev && e == 0) begin
            n_err++;
            $display("FAIL %s stat: got %0d expected %0d", tag, stat_q, e);
        end
    endtask

    task automatic read_stat(input logic [1:0] e, input string tag);
        @(negedge clk);
        n_chk++;
        if (stat_q !== e) begin
            n_err++;
            $display("FAIL %s read: got %0d expected %0d", tag, stat_q, e);
        end
        stat_rd = 1'b1;
        @(posedge clk); #1;
        stat_rd = 1'b0;
        check_stat(2'd0, tag);
    endtask

    task automatic busy(input int len, input int lim);
        int s;
        @(negedge clk);
        bus_busy_n = 1'b0;
        s = cyc;
        if (lim > 0) begin
            exp_cyc.push_back(s + lim);
            exp_bit.push_back(1);
        end
        repeat (len) @(negedge clk);
        bus_busy_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: run hung at edge %0d, expected completion", cyc);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int w;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        n_chk++;
        if (tc_out !== 1'b0) begin n_err++; $display("FAIL R1 tc: got %0b expected 0", tc_out); end
        check_stat(2'd0, "R1");
        // R1: watchdog count 0 after reset never expires
        wr(1'b0, prog(1, 0, 0, 1, 0), w);
        idle(50);
        check_stat(2'd0, "R1");

        // R2 R8: 4 MHz, watchdog enabled, count 5 -> 20 clocks
        wr(1'b0, prog(4, 0, 0, 1, 0), w);
        arm(5, 4, 0);
        idle(30);
        check_stat(2'b01, "R13");   // still set before read
        read_stat(2'b01, "R8");

        // R10: reload delays expiry
        wr(1'b1, 16'd3, w);
        idle(8);
        arm(3, 4, 0);
        idle(20);
        read_stat(2'b01, "R10");

        // R10: writing 0 cancels
        wr(1'b1, 16'd6, w);
        idle(5);
        wr(1'b1, 16'd0, w);
        idle(60);
        check_stat(2'd0, "R10");

        // R11: frozen while disabled, resumes on enable
        wr(1'b0, prog(4, 0, 0, 0, 0), w);
        wr(1'b1, 16'd2, w);
        idle(100);
        check_stat(2'd0, "R11");
        wr(1'b0, prog(4, 0, 0, 1, 0), w);
        exp_cyc.push_back(w + 8); exp_bit.push_back(0);
        idle(20);
        read_stat(2'b01, "R11");

        // R3: zero frequency gives no tick, then divide by 3
        wr(1'b0, prog(0, 0, 0, 1, 0), w);
        wr(1'b1, 16'd1, w);
        idle(300);
        check_stat(2'd0, "R3");
        wr(1'b0, prog(3, 0, 0, 1, 0), w);
        exp_cyc.push_back(w + 3); exp_bit.push_back(0);
        idle(10);
        read_stat(2'b01, "R3");

        // R9: slow tick, 2 MHz, count 3 -> 6000 clocks
        wr(1'b0, prog(2, 0, 0, 1, 1), w);
        arm(3, 2, 1);
        idle(6010);
        read_stat(2'b01, "R9");

        // R4: short limit 64
        wr(1'b0, prog(0, 1, 0, 0, 0), w);
        busy(64, 64);
        idle(3);
        read_stat(2'b10, "R4");

        // R12: one pulse per long bus cycle
        busy(150, 64);
        idle(3);
        read_stat(2'b10, "R12");

        // R6: short runs do not accumulate
        busy(63, 0);
        idle(2);
        busy(63, 0);
        check_stat(2'd0, "R6");
        busy(64, 64);
        idle(2);
        read_stat(2'b10, "R6");

        // R5: long limit 128
        wr(1'b0, prog(0, 1, 1, 0, 0), w);
        busy(127, 0);
        check_stat(2'd0, "R5");
        busy(128, 128);
        idle(2);
        read_stat(2'b10, "R5");

        // R7: disabled time-out
        wr(1'b0, prog(0, 0, 0, 0, 0), w);
        busy(200, 0);
        idle(2);
        check_stat(2'd0, "R7");

        // R12: both events, separate flags
        wr(1'b0, prog(5, 1, 0, 1, 0), w);
        arm(20, 5, 0);
        busy(64, 64);
        idle(50);
        read_stat(2'b11, "R12");

        // R8: every expected pulse seen
        n_chk++;
        if (exp_cyc.size() != 0) begin
            n_err++;
            $display("FAIL R8 missing pulses: got %0d pending expected 0", exp_cyc.size());
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule